// File: doc/BRIEF.md
# I2C Memory Target Engine

This block is the serial-bus side of an 8192 x 8 byte-addressed non-volatile memory. It watches the I2C clock and data lines, which a faster system clock oversamples. It answers a 7-bit device address made of a fixed 4-bit identifier and three strap inputs. It takes a two-byte memory address and then moves data between the bus and a simple internal memory port. Received data bytes go to a page buffer as single-cycle write strobes. When a STOP ends a transaction that carried data, a commit pulse tells the write controller to start its internal write cycle. Read data is taken from a combinational read port addressed by the engine's pointer.

The address pointer survives between transactions. A read with no address phase therefore continues one past the last byte touched. A write streams within one page and wraps on the low address bits. A read streams through the whole array and wraps from the top address to zero. While the write controller reports busy, the engine stays silent on its own address, so a master can poll until it gets an acknowledge. An external reset input aborts any transfer and keeps the engine deaf while it is held.

Top module: `i2c_mem_target`

## Requirements
- R1: A START (data falling while clock is high) is needed before any response; clocks and bytes before the first START are ignored, a STOP (data rising while clock is high) returns the engine to idle, and the engine never changes its data drive while the clock stays high.
- R2: The engine answers only the device byte whose upper seven bits are binary 1010 followed by `strap[2:0]` (strap bit 2 first); bit 0 of that byte is the direction, 1 for read and 0 for write. Any other device byte gets no acknowledge.
- R3: The engine acknowledges (drives `sda_pull` high) during the ninth clock after a matching device byte and after every byte received in write direction.
- R4: In write direction the first two bytes after the device byte form the memory address, high byte first; only the low 5 bits of the high byte are used, and its upper 3 bits are ignored.
- R5: Each data byte gives one `mem_wr` pulse with `mem_addr` equal to the current pointer and `mem_wdata` equal to the byte; the pointer then advances by one within a 64-byte page (low 6 bits wrap, upper 7 bits unchanged).
- R6: A STOP that ends a write transaction with at least one data byte produces one `mem_commit` pulse; transactions without data bytes produce none.
- R7: A read that follows the device byte directly returns data from the address one past the last byte written or read.
- R8: A write that sends only the two address bytes, followed by a repeated START and a read device byte, starts reading at the address just sent.
- R9: In read direction each master acknowledge makes the next byte follow from the next address; the read pointer wraps from 0x1FFF to 0x0000.
- R10: A read byte that the master does not acknowledge ends the transfer; the engine releases the data line and ignores further clocks until a START or STOP.
- R11: While `wr_busy` is high, a matching device byte gets no acknowledge; once `wr_busy` is low, the same byte is acknowledged.
- R12: While `ext_rst` is high, any transfer in progress is aborted with the data line released, and a new START is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_rst | input | 1 | Supply-monitor reset, active high, synchronous to clk |
| scl_in | input | 1 | Bus clock line as received |
| sda_in | input | 1 | Bus data line as received |
| strap | input | 3 | Device address strap pins |
| wr_busy | input | 1 | Internal write cycle in progress |
| mem_rdata | input | 8 | Read data at `mem_addr` (combinational) |
| sda_pull | output | 1 | 1 pulls the data line low |
| mem_addr | output | 13 | Current address pointer |
| mem_wr | output | 1 | One-cycle strobe of a received data byte to the page buffer |
| mem_wdata | output | 8 | Data byte for `mem_wr` |
| mem_commit | output | 1 | One-cycle pulse asking the write controller to program the page |

## Verification
The bench builds the engine with its default parameters: a 13-bit address, a 64-byte page and two synchronizer stages. With these values a page-boundary write (starting at 0x13E) and a read across the top of the array (starting at 0x1FFE) each fit in a few bytes, so both wrap rules are exercised directly. The master runs the line at a quarter-period of eight system clocks. This leaves the engine's synchronizer-and-register latency inside the low phase, so the check that the drive never changes while the clock is high is meaningful on every clock.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_DEV  = 3'd1,
    ST_AHI  = 3'd2,
    ST_ALO  = 3'd3,
    ST_WDAT = 3'd4,
    ST_RD   = 3'd5
  } tgt_state_e;

  localparam logic [3:0] DEV_ID = 4'b1010;

endpackage

// File: rtl/i2c_tgt_sync.sv
module i2c_tgt_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_in,
  input  logic sda_in,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);

  localparam int NL = 2;

  logic [NL-1:0] raw;
  logic [NL-1:0] cur;
  logic [NL-1:0] prv;

  assign raw = {sda_in, scl_in};

  for (genvar g = 0; g < NL; g++) begin : g_line
    logic [STAGES-1:0] chain_q;
    logic              prv_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        chain_q <= '1;
        prv_q   <= 1'b1;
      end else begin
        chain_q <= {chain_q[STAGES-2:0], raw[g]};
        prv_q   <= chain_q[STAGES-1];
      end
    end

    assign cur[g] = chain_q[STAGES-1];
    assign prv[g] = prv_q;
  end

  assign sda_s     = cur[1];
  assign scl_rise  = cur[0] & ~prv[0];
  assign scl_fall  = ~cur[0] & prv[0];
  assign start_det = cur[0] & prv[0] & prv[1] & ~cur[1];
  assign stop_det  = cur[0] & prv[0] & ~prv[1] & cur[1];

  // R1: bus events are mutually exclusive in any cycle
  a_r1_events_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({scl_rise, scl_fall, start_det, stop_det}));

endmodule

// File: rtl/i2c_tgt_ptr.sv
module i2c_tgt_ptr #(
  parameter int ADDR_W = 13,
  parameter int PAGE_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] load_val,
  input  logic              inc_page,
  input  logic              inc_full,
  output logic [ADDR_W-1:0] ptr
);

  logic [ADDR_W-1:0] ptr_q;
  logic [ADDR_W-1:0] ptr_d;
  logic              ptr_en;

  assign ptr_en = load | inc_page | inc_full;

  always_comb begin
    ptr_d = ptr_q;
    if (load) begin
      ptr_d = load_val;
    end else if (inc_page) begin
      ptr_d = {ptr_q[ADDR_W-1:PAGE_W], ptr_q[PAGE_W-1:0] + PAGE_W'(1)};
    end else if (inc_full) begin
      ptr_d = ptr_q + ADDR_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q <= '0;
    end else if (ptr_en) begin
      ptr_q <= ptr_d;
    end
  end

  assign ptr = ptr_q;

  // R9: read stream wraps from the top address to zero
  a_r9_full_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (inc_full && !load && !inc_page && (&ptr_q)) |=> (ptr_q == '0));

  // R5: page streaming keeps the page number
  a_r5_page_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (inc_page && !load) |=> (ptr_q[ADDR_W-1:PAGE_W] == $past(ptr_q[ADDR_W-1:PAGE_W])));

endmodule

// File: rtl/i2c_tgt_fsm.sv
module i2c_tgt_fsm
  import i2c_tgt_pkg::*;
#(
  parameter int ADDR_W = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              abort,
  input  logic              start_det,
  input  logic              stop_det,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              sda_s,
  input  logic [2:0]        strap,
  input  logic              wr_busy,
  input  logic [7:0]        rdata,
  output logic              ptr_load,
  output logic [ADDR_W-1:0] ptr_val,
  output logic              ptr_inc_page,
  output logic              ptr_inc_full,
  output logic              mem_wr,
  output logic [7:0]        mem_wdata,
  output logic              mem_commit,
  output logic              sda_pull
);

  localparam int HI_W = ADDR_W - 8;

  tgt_state_e      state_q, state_d;
  logic [3:0]      bitcnt_q, bitcnt_d;
  logic [7:0]      shreg_q, shreg_d;
  logic [HI_W-1:0] hi_q, hi_d;
  logic            ack_ph_q, ack_ph_d;
  logic            pull_q, pull_d;
  logic            mack_q, mack_d;
  logic            wrote_q, wrote_d;
  logic            wr_q, wr_d;
  logic            commit_q, commit_d;
  logic            byte_done;
  logic            dev_match;

  assign byte_done = scl_fall & ~ack_ph_q & (bitcnt_q == 4'd8);
  assign dev_match = (shreg_q[7:1] == {DEV_ID, strap});
  assign ptr_val   = {hi_q, shreg_q};

  always_comb begin
    state_d      = state_q;
    bitcnt_d     = bitcnt_q;
    shreg_d      = shreg_q;
    hi_d         = hi_q;
    ack_ph_d     = ack_ph_q;
    pull_d       = pull_q;
    mack_d       = mack_q;
    wrote_d      = wrote_q;
    wr_d         = 1'b0;
    commit_d     = 1'b0;
    ptr_load     = 1'b0;
    ptr_inc_page = 1'b0;
    ptr_inc_full = 1'b0;

    if (abort) begin
      state_d  = ST_IDLE;
      pull_d   = 1'b0;
      ack_ph_d = 1'b0;
      wrote_d  = 1'b0;
    end else if (start_det) begin
      state_d  = ST_DEV;
      bitcnt_d = '0;
      ack_ph_d = 1'b0;
      pull_d   = 1'b0;
      wrote_d  = 1'b0;
    end else if (stop_det) begin
      state_d  = ST_IDLE;
      ack_ph_d = 1'b0;
      pull_d   = 1'b0;
      commit_d = wrote_q;
      wrote_d  = 1'b0;
    end else begin
      unique case (state_q)
        ST_DEV, ST_AHI, ST_ALO, ST_WDAT: begin
          if (scl_rise && !ack_ph_q && (bitcnt_q != 4'd8)) begin
            shreg_d  = {shreg_q[6:0], sda_s};
            bitcnt_d = bitcnt_q + 4'd1;
          end else if (byte_done) begin
            ack_ph_d = 1'b1;
            pull_d   = 1'b1;
            if (state_q == ST_DEV && (!dev_match || wr_busy)) begin
              state_d  = ST_IDLE;
              ack_ph_d = 1'b0;
              pull_d   = 1'b0;
            end
            if (state_q == ST_AHI) hi_d = shreg_q[HI_W-1:0];
            if (state_q == ST_ALO) ptr_load = 1'b1;
            if (state_q == ST_WDAT) begin
              wr_d    = 1'b1;
              wrote_d = 1'b1;
            end
          end else if (scl_fall && ack_ph_q) begin
            ack_ph_d = 1'b0;
            bitcnt_d = '0;
            pull_d   = 1'b0;
            unique case (state_q)
              ST_DEV: begin
                if (shreg_q[0]) begin
                  state_d = ST_RD;
                  shreg_d = rdata;
                  pull_d  = ~rdata[7];
                end else begin
                  state_d = ST_AHI;
                end
              end
              ST_AHI:  state_d = ST_ALO;
              ST_ALO:  state_d = ST_WDAT;
              default: ptr_inc_page = 1'b1;
            endcase
          end
        end
        ST_RD: begin
          if (scl_fall && !ack_ph_q) begin
            if (bitcnt_q == 4'd7) begin
              pull_d       = 1'b0;
              ack_ph_d     = 1'b1;
              bitcnt_d     = '0;
              ptr_inc_full = 1'b1;
            end else begin
              shreg_d  = {shreg_q[6:0], 1'b0};
              pull_d   = ~shreg_q[6];
              bitcnt_d = bitcnt_q + 4'd1;
            end
          end else if (scl_rise && ack_ph_q) begin
            mack_d = ~sda_s;
          end else if (scl_fall && ack_ph_q) begin
            ack_ph_d = 1'b0;
            if (mack_q) begin
              shreg_d  = rdata;
              pull_d   = ~rdata[7];
              bitcnt_d = '0;
            end else begin
              state_d = ST_IDLE;
              pull_d  = 1'b0;
            end
          end
        end
        default: begin
          pull_d = 1'b0;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      bitcnt_q <= '0;
      shreg_q  <= '0;
      hi_q     <= '0;
      ack_ph_q <= 1'b0;
      pull_q   <= 1'b0;
      mack_q   <= 1'b0;
      wrote_q  <= 1'b0;
      wr_q     <= 1'b0;
      commit_q <= 1'b0;
    end else begin
      state_q  <= state_d;
      bitcnt_q <= bitcnt_d;
      shreg_q  <= shreg_d;
      hi_q     <= hi_d;
      ack_ph_q <= ack_ph_d;
      pull_q   <= pull_d;
      mack_q   <= mack_d;
      wrote_q  <= wrote_d;
      wr_q     <= wr_d;
      commit_q <= commit_d;
    end
  end

  assign sda_pull   = pull_q;
  assign mem_wr     = wr_q;
  assign mem_wdata  = shreg_q;
  assign mem_commit = commit_q;

  // R12: an external reset releases the line on the next cycle
  a_r12_abort_release: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> (!sda_pull && state_q == ST_IDLE));

  // R11: busy write controller means the address is not acknowledged
  a_r11_busy_nack: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_DEV && byte_done && wr_busy && !abort && !start_det && !stop_det)
      |=> (!sda_pull && state_q == ST_IDLE));

  // R5: a write strobe only happens in the acknowledge slot of a data byte
  a_r5_wr_in_ack: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr |-> (ack_ph_q && state_q == ST_WDAT));

  // R6: commit pulses follow a STOP
  a_r6_commit_on_stop: assert property (@(posedge clk) disable iff (!rst_n)
    mem_commit |-> $past(stop_det));

  // R1: idle engine never drives the line
  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE) |-> !sda_pull);

endmodule

// File: rtl/i2c_mem_target.sv
module i2c_mem_target #(
  parameter int ADDR_W      = 13,
  parameter int PAGE_W      = 6,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ext_rst,
  input  logic              scl_in,
  input  logic              sda_in,
  input  logic [2:0]        strap,
  input  logic              wr_busy,
  input  logic [7:0]        mem_rdata,
  output logic              sda_pull,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_wr,
  output logic [7:0]        mem_wdata,
  output logic              mem_commit
);

  logic              sda_s;
  logic              scl_rise;
  logic              scl_fall;
  logic              start_det;
  logic              stop_det;
  logic              ptr_load;
  logic [ADDR_W-1:0] ptr_val;
  logic              ptr_inc_page;
  logic              ptr_inc_full;

  i2c_tgt_sync #(
    .STAGES (SYNC_STAGES)
  ) u_sync (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_in    (scl_in),
    .sda_in    (sda_in),
    .sda_s     (sda_s),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det)
  );

  i2c_tgt_fsm #(
    .ADDR_W (ADDR_W)
  ) u_fsm (
    .clk          (clk),
    .rst_n        (rst_n),
    .abort        (ext_rst),
    .start_det    (start_det),
    .stop_det     (stop_det),
    .scl_rise     (scl_rise),
    .scl_fall     (scl_fall),
    .sda_s        (sda_s),
    .strap        (strap),
    .wr_busy      (wr_busy),
    .rdata        (mem_rdata),
    .ptr_load     (ptr_load),
    .ptr_val      (ptr_val),
    .ptr_inc_page (ptr_inc_page),
    .ptr_inc_full (ptr_inc_full),
    .mem_wr       (mem_wr),
    .mem_wdata    (mem_wdata),
    .mem_commit   (mem_commit),
    .sda_pull     (sda_pull)
  );

  i2c_tgt_ptr #(
    .ADDR_W (ADDR_W),
    .PAGE_W (PAGE_W)
  ) u_ptr (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (ptr_load),
    .load_val (ptr_val),
    .inc_page (ptr_inc_page),
    .inc_full (ptr_inc_full),
    .ptr      (mem_addr)
  );

endmodule

// File: tb/sim_i2c_mem_target.sv
module sim_i2c_mem_target;

  localparam int Q = 8;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        ext_rst;
  logic        scl_m;
  logic        sda_m;
  logic [2:0]  strap;
  logic        wr_busy;
  logic [7:0]  mem_rdata;
  logic        sda_pull;
  logic [12:0] mem_addr;
  logic        mem_wr;
  logic [7:0]  mem_wdata;
  logic        mem_commit;
  logic        sda_bus;

  int checks = 0;
  int fails  = 0;
  int commits = 0;
  int stab_err = 0;
  bit done = 1'b0;
  int exp_a[$];
  int exp_d[$];

  always #10 clk = ~clk;

  function automatic logic [7:0] pat(input logic [12:0] a);
    return a[7:0] ^ {3'b000, a[12:8]} ^ 8'h5A;
  endfunction

  assign sda_bus   = sda_m & ~sda_pull;
  assign mem_rdata = pat(mem_addr);

  i2c_mem_target u0 (
    .clk        (clk),
    .rst_n      (rst_n),
    .ext_rst    (ext_rst),
    .scl_in     (scl_m),
    .sda_in     (sda_bus),
    .strap      (strap),
    .wr_busy    (wr_busy),
    .mem_rdata  (mem_rdata),
    .sda_pull   (sda_pull),
    .mem_addr   (mem_addr),
    .mem_wr     (mem_wr),
    .mem_wdata  (mem_wdata),
    .mem_commit (mem_commit)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // per-clock reference comparison: writes, commits, line stability
  logic [2:0] scl_hist = 3'b000;
  logic       pull_prev = 1'b0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (mem_wr) begin
        if (exp_a.size() == 0) begin
          chk(1'b0, "R5 unexpected write strobe", int'(mem_addr), -1);
        end else begin
          int ea;
          int ed;
          ea = exp_a.pop_front();
          ed = exp_d.pop_front();
          chk(int'(mem_addr) == ea, "R5 write address", int'(mem_addr), ea);
          chk(int'(mem_wdata) == ed, "R5 write data", int'(mem_wdata), ed);
        end
      end
      if (mem_commit) commits++;
      if (!ext_rst && (&scl_hist) && scl_m && (sda_pull != pull_prev)) stab_err++;
    end
    scl_hist  = {scl_hist[1:0], scl_m};
    pull_prev = sda_pull;
  end

  task automatic wq();
    repeat (Q) @(negedge clk);
  endtask

  task automatic start_c();
    sda_m = 1'b1; wq();
    scl_m = 1'b1; wq();
    sda_m = 1'b0; wq();
    scl_m = 1'b0; wq();
  endtask

  task automatic stop_c();
    sda_m = 1'b0; wq();
    scl_m = 1'b1; wq();
    sda_m = 1'b1; wq();
  endtask

  task automatic clk_bit(input logic b, output logic s);
    sda_m = b; wq();
    scl_m = 1'b1; wq();
    s = sda_bus; wq();
    scl_m = 1'b0; wq();
  endtask

  task automatic wr_byte(input logic [7:0] b, output logic ack);
    logic s;
    for (int i = 7; i >= 0; i--) clk_bit(b[i], s);
    clk_bit(1'b1, s);
    ack = ~s;
  endtask

  task automatic rd_byte(input logic mack, output logic [7:0] d);
    logic s;
    for (int i = 7; i >= 0; i--) begin
      clk_bit(1'b1, s);
      d[i] = s;
    end
    clk_bit(~mack, s);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic       ack;
    logic [7:0] d;
    logic       s;
    rst_n   = 1'b0;
    ext_rst = 1'b0;
    scl_m   = 1'b1;
    sda_m   = 1'b1;
    strap   = 3'b101;
    wr_busy = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    wq();

    // reset state
    chk(sda_pull == 1'b0, "R1 reset sda_pull", int'(sda_pull), 0);
    chk(mem_wr == 1'b0, "R5 reset mem_wr", int'(mem_wr), 0);
    chk(mem_addr == 13'h0, "R7 reset pointer", int'(mem_addr), 0);

    // R1: bytes without a START are ignored
    scl_m = 1'b0; wq();
    wr_byte(8'hAA, ack);
    chk(ack == 1'b0, "R1 no ack before START", int'(ack), 0);
    stop_c();

    // R2: wrong strap and wrong identifier (device byte = 1010 strap rw)
    start_c();
    wr_byte(8'hA2, ack);
    chk(ack == 1'b0, "R2 wrong strap nack", int'(ack), 0);
    stop_c();
    start_c();
    wr_byte(8'h2A, ack);
    chk(ack == 1'b0, "R2 wrong identifier nack", int'(ack), 0);
    stop_c();

    // R3 R4 R5 R6: page write crossing the 64-byte boundary
    exp_a.push_back(13'h13E); exp_d.push_back(8'h11);
    exp_a.push_back(13'h13F); exp_d.push_back(8'h22);
    exp_a.push_back(13'h100); exp_d.push_back(8'h33);
    exp_a.push_back(13'h101); exp_d.push_back(8'h44);
    start_c();
    wr_byte(8'hAA, ack); chk(ack, "R3 ack device write", int'(ack), 1);
    wr_byte(8'hE1, ack); chk(ack, "R4 ack high address", int'(ack), 1);
    wr_byte(8'h3E, ack); chk(ack, "R4 ack low address", int'(ack), 1);
    wr_byte(8'h11, ack); chk(ack, "R3 ack data 0", int'(ack), 1);
    wr_byte(8'h22, ack); chk(ack, "R3 ack data 1", int'(ack), 1);
    wr_byte(8'h33, ack); chk(ack, "R3 ack data 2", int'(ack), 1);
    wr_byte(8'h44, ack); chk(ack, "R3 ack data 3", int'(ack), 1);
    chk(commits == 0, "R6 no commit before STOP", commits, 0);
    stop_c();
    wq();
    chk(exp_a.size() == 0, "R5 all strobes seen", exp_a.size(), 0);
    chk(commits == 1, "R6 one commit after STOP", commits, 1);

    // R7: current-address read continues after last written byte
    start_c();
    wr_byte(8'hAB, ack); chk(ack, "R7 ack device read", int'(ack), 1);
    rd_byte(1'b0, d);
    chk(d == pat(13'h102), "R7 current address data", int'(d), int'(pat(13'h102)));
    stop_c();

    // R8 R9: random read near the top of the array
    start_c();
    wr_byte(8'hAA, ack);
    wr_byte(8'h1F, ack);
    wr_byte(8'hFE, ack);
    chk(ack, "R8 ack dummy write address", int'(ack), 1);
    start_c();
    wr_byte(8'hAB, ack); chk(ack, "R8 ack repeated-start read", int'(ack), 1);
    rd_byte(1'b1, d);
    chk(d == pat(13'h1FFE), "R8 random read data", int'(d), int'(pat(13'h1FFE)));
    rd_byte(1'b1, d);
    chk(d == pat(13'h1FFF), "R9 sequential data", int'(d), int'(pat(13'h1FFF)));
    rd_byte(1'b0, d);
    chk(d == pat(13'h0000), "R9 wrap to zero", int'(d), int'(pat(13'h0000)));

    // R10: after the master's missing ack the engine stays off the line
    rd_byte(1'b0, d);
    chk(d == 8'hFF, "R10 silent after nack", int'(d), 8'hFF);
    stop_c();
    wq();
    chk(commits == 1, "R6 no commit for address-only write", commits, 1);
    start_c();
    wr_byte(8'hAB, ack);
    rd_byte(1'b0, d);
    chk(d == pat(13'h0001), "R7 pointer after wrap", int'(d), int'(pat(13'h0001)));
    stop_c();

    // R11: busy write controller, acknowledge polling
    wr_busy = 1'b1;
    start_c();
    wr_byte(8'hAA, ack);
    chk(ack == 1'b0, "R11 no ack while busy", int'(ack), 0);
    stop_c();
    start_c();
    wr_byte(8'hAB, ack);
    chk(ack == 1'b0, "R11 no read ack while busy", int'(ack), 0);
    stop_c();
    wr_busy = 1'b0;
    start_c();
    wr_byte(8'hAA, ack);
    chk(ack == 1'b1, "R11 ack after busy clears", int'(ack), 1);
    stop_c();

    // R12: external reset aborts a read and blocks new transfers
    start_c();
    wr_byte(8'hAB, ack);
    chk(ack == 1'b1, "R12 ack before abort", int'(ack), 1);
    for (int i = 0; i < 3; i++) clk_bit(1'b1, s);
    ext_rst = 1'b1;
    wq();
    chk(sda_pull == 1'b0, "R12 line released on abort", int'(sda_pull), 0);
    d = 8'hFF;
    for (int i = 0; i < 5; i++) begin
      clk_bit(1'b1, s);
      d[i] = s;
    end
    chk(d == 8'hFF, "R12 no drive during abort", int'(d), 8'hFF);
    stop_c();
    start_c();
    wr_byte(8'hAA, ack);
    chk(ack == 1'b0, "R12 new START ignored", int'(ack), 0);
    stop_c();
    ext_rst = 1'b0;
    wq();
    start_c();
    wr_byte(8'hAA, ack);
    chk(ack == 1'b1, "R12 ack after release", int'(ack), 1);
    stop_c();
    wq();

    chk(stab_err == 0, "R1 drive stable while clock high", stab_err, 0);
    chk(commits == 1, "R6 total commits", commits, 1);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule